// File: doc/BRIEF.md
# Software Write-Lock Command Detector

This block sits on the write path of a byte-wide non-volatile array. It sees every write cycle as a one-clock pulse with an address and a data byte, and it decides in that same cycle whether the array may commit the write. It holds one bit of state that says whether the array is locked.

A three-write lock prefix arms the block. The write that follows the prefix is committed whatever its address and data, and the lock engages after it. A six-write release sequence clears the lock. Writes in a sequence must follow one another within a programmable gap, counted in clocks. A write that does not fit the expected step drops the detector back to idle. The exception is a write of the first command pair, which starts a new sequence.

While the lock is clear, every write passes, command bytes included. While it is set, nothing reaches the array except the one write that follows a complete lock prefix. A flag marks each write that was recognised as a command byte.

Top module: `wprot_seq_guard`

## Requirements
- R1: After reset `protected_o` equals parameter INIT_PROTECT (default 0, unlocked) and no sequence is in progress.
- R2: While unlocked, `wr_allow_o` is high in every cycle in which `wr_valid_i` is high, command bytes included; it is combinational in the same cycle.
- R3: The lock prefix is address 0x05555 with data 0xAA, then 0x02AAA with 0x55, then 0x05555 with 0xA0. Each of these three writes raises `cmd_byte_o`. The next write, at any address and with any data, is allowed with `cmd_byte_o` low, and `protected_o` is 1 from the following cycle.
- R4: While locked, ordinary writes and command bytes are refused (`wr_allow_o` low).
- R5: While locked, a complete lock prefix lets its following write through, and the lock stays set.
- R6: The release sequence is 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x80, 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x20. While locked, all six writes are refused and flagged. `protected_o` is 0 from the cycle after the sixth, and later writes are allowed.
- R7: For the 0x55 steps, address bits 16 and 15 are ignored, so 0x0AAAA also matches. For the 0x05555 steps, the full address must match.
- R8: Consecutive writes of a sequence, including the write that follows the lock prefix, may be up to WINDOW_CLKS clocks apart (a gap of WINDOW_CLKS is accepted). A larger gap abandons the sequence; cycles with no valid write do not otherwise disturb it.
- R9: A write that does not match the expected step returns the detector to idle. If that write is 0x05555/0xAA, it is flagged and becomes step one of a new sequence.
- R10: `cmd_byte_o` is high only together with `wr_valid_i`, and only on recognised command bytes. Ordinary writes and the write that follows the lock prefix leave it low.
- R11: After the first two command writes, data 0xA0 at 0x05555 takes the lock path and 0x80 takes the release path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One-cycle write pulse |
| wr_addr_i | input | ADDR_W (17) | Write address |
| wr_data_i | input | DATA_W (8) | Write data |
| wr_allow_o | output | 1 | The array may commit this write |
| cmd_byte_o | output | 1 | This write is a recognised command byte |
| protected_o | output | 1 | Current lock state |

## Verification
Two functions can meet in the same cycle: the gap timer runs out, and the next command byte arrives. A write placed at a gap of exactly WINDOW_CLKS must still be accepted, so it arrives in the last cycle the timer allows. A write at WINDOW_CLKS+1 must find the detector idle. In both cases the bench judges the outcome from `cmd_byte_o` on that write and from `wr_allow_o` on the write that follows. A second collision is a lock prefix followed by a write that happens to be the first command pair. It is also provoked, by writing that pair straight after a timed-out prefix; the bench expects it to be refused and flagged, while the lock stays set.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_B1   = 3'd1,  // 1st pair seen, expect alt/55
    ST_B2   = 3'd2,  // expect main/A0 or main/80
    ST_ARM  = 3'd3,  // next write is committed, then lock
    ST_U3   = 3'd4,  // release: expect main/AA
    ST_U4   = 3'd5,  // release: expect alt/55
    ST_U5   = 3'd6   // release: expect main/20
  } step_e;

  localparam logic [15:0] MAIN_ADDR = 16'h5555;
  localparam logic [14:0] ALT_ADDR  = 15'h2AAA;
  localparam int          ALT_BITS  = 15;

  localparam logic [7:0] D_START = 8'hAA;
  localparam logic [7:0] D_SECND = 8'h55;
  localparam logic [7:0] D_LOCK  = 8'hA0;
  localparam logic [7:0] D_REL1  = 8'h80;
  localparam logic [7:0] D_REL2  = 8'h20;

endpackage

// File: rtl/wprot_seq_match.sv
module wprot_seq_match
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output step_e             step_nxt_o,
  output logic              hit_o,
  output logic              arm_fire_o,
  output logic              unlock_o
);

  logic at_main, at_alt, is_start;

  assign at_main  = (addr_i == ADDR_W'(MAIN_ADDR));
  assign at_alt   = (addr_i[ALT_BITS-1:0] == ALT_ADDR);  // upper bits aliased
  assign is_start = at_main && (data_i == DATA_W'(D_START));

  always_comb begin
    step_nxt_o = ST_IDLE;
    hit_o      = 1'b0;
    arm_fire_o = 1'b0;
    unlock_o   = 1'b0;
    case (step_i)
      ST_ARM: arm_fire_o = 1'b1;
      ST_B1, ST_U4: begin
        if (at_alt && data_i == DATA_W'(D_SECND)) begin
          step_nxt_o = (step_i == ST_B1) ? ST_B2 : ST_U5;
          hit_o      = 1'b1;
        end
      end
      ST_B2: begin
        if (at_main && data_i == DATA_W'(D_LOCK)) begin
          step_nxt_o = ST_ARM;
          hit_o      = 1'b1;
        end else if (at_main && data_i == DATA_W'(D_REL1)) begin
          step_nxt_o = ST_U3;
          hit_o      = 1'b1;
        end
      end
      ST_U3: begin
        if (is_start) begin
          step_nxt_o = ST_U4;
          hit_o      = 1'b1;
        end
      end
      ST_U5: begin
        if (at_main && data_i == DATA_W'(D_REL2)) begin
          hit_o    = 1'b1;
          unlock_o = 1'b1;
        end
      end
      default: ;
    endcase
    // mismatch that is itself the opening pair restarts at step one
    if (!hit_o && !arm_fire_o && step_i != ST_U3 && is_start) begin
      step_nxt_o = ST_B1;
      hit_o      = 1'b1;
    end
  end

endmodule

// File: rtl/wprot_gap_timer.sv
module wprot_gap_timer #(
  parameter int WINDOW_CLKS = 1500,
  localparam int CNT_W = $clog2(WINDOW_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic wr_valid_i,
  output logic expire_o
);

  logic [CNT_W-1:0] tmr_q;

  assign expire_o = active_i && !wr_valid_i && (tmr_q == CNT_W'(WINDOW_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                tmr_q <= '0;
    else if (wr_valid_i || !active_i || expire_o) tmr_q <= '0;
    else                                        tmr_q <= tmr_q + 1'b1;
  end

  p_tmr_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q < CNT_W'(WINDOW_CLKS));

endmodule

// File: rtl/wprot_state.sv
module wprot_state #(
  parameter bit INIT_PROTECT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic unlock_i,
  output logic prot_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prot_o <= INIT_PROTECT;
    else if (lock_i)   prot_o <= 1'b1;
    else if (unlock_i) prot_o <= 1'b0;
  end

endmodule

// File: rtl/wprot_seq_guard.sv
module wprot_seq_guard
  import wprot_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int WINDOW_CLKS = 1500,
  parameter bit INIT_PROTECT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_allow_o,
  output logic              cmd_byte_o,
  output logic              protected_o
);

  step_e step_q, step_nxt;
  logic  hit, arm_fire, unlock, expire, prot_q;

  wprot_seq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_match (
    .step_i    (step_q),
    .addr_i    (wr_addr_i),
    .data_i    (wr_data_i),
    .step_nxt_o(step_nxt),
    .hit_o     (hit),
    .arm_fire_o(arm_fire),
    .unlock_o  (unlock)
  );

  wprot_gap_timer #(.WINDOW_CLKS(WINDOW_CLKS)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (step_q != ST_IDLE),
    .wr_valid_i(wr_valid_i),
    .expire_o  (expire)
  );

  wprot_state #(.INIT_PROTECT(INIT_PROTECT)) i_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (wr_valid_i && arm_fire),
    .unlock_i(wr_valid_i && unlock),
    .prot_o  (prot_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         step_q <= ST_IDLE;
    else if (wr_valid_i) step_q <= step_nxt;
    else if (expire)     step_q <= ST_IDLE;
  end

  assign wr_allow_o  = wr_valid_i && (!prot_q || step_q == ST_ARM);
  assign cmd_byte_o  = wr_valid_i && hit;
  assign protected_o = prot_q;

  p_lock_after_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_q) |-> $past(wr_valid_i && step_q == ST_ARM));

  p_unlock_after_rel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_q) |-> $past(wr_valid_i && step_q == ST_U5 && unlock));

  p_block_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_q && wr_valid_i && step_q != ST_ARM) |-> !wr_allow_o);

  p_cmd_with_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_byte_o |-> wr_valid_i);

  p_idle_only_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_valid_i) && step_q != $past(step_q)) |-> step_q == ST_IDLE);

endmodule

// File: tb/test_wprot_seq_guard.sv
module test_wprot_seq_guard;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  data = '0;
  logic        allow, cmd, prot;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_seq_guard #(.WINDOW_CLKS(W)) i_wprot_seq_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(valid), .wr_addr_i(addr),
    .wr_data_i(data), .wr_allow_o(allow), .cmd_byte_o(cmd), .protected_o(prot)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // one write cycle; checks same-cycle outputs
  task automatic wr(logic [16:0] a, logic [7:0] d, logic e_allow, logic e_cmd, string req);
    @(negedge clk);
    valid = 1'b1; addr = a; data = d;
    #1;
    chk({req, " allow"}, allow, e_allow);
    chk({req, " cmd"}, cmd, e_cmd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
    end
  endtask

  task automatic chk_prot(logic e, string req);  // uses one idle cycle
    idle(1);
    #1;
    chk({req, " protected"}, prot, e);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset", prot, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    chk_prot(1'b0, "R1");
  endtask

  task automatic t_open_pass;
    wr(17'h00123, 8'h5A, 1, 0, "R2 plain");
    wr(17'h05555, 8'hAA, 1, 1, "R2 cmd unlocked");
    wr(17'h02AAA, 8'h55, 1, 1, "R10 cmd unlocked");
    wr(17'h05555, 8'h80, 1, 1, "R11 rel path");
    wr(17'h00040, 8'h01, 1, 0, "R9 mismatch");
    chk_prot(1'b0, "R2");
  endtask

  task automatic t_lock;
    wr(17'h05555, 8'hAA, 1, 1, "R3 b1");
    wr(17'h02AAA, 8'h55, 1, 1, "R3 b2");
    wr(17'h05555, 8'hA0, 1, 1, "R11 lock path");
    wr(17'h01000, 8'h77, 1, 0, "R3 fourth");
    chk_prot(1'b1, "R3");
  endtask

  task automatic t_blocked;
    wr(17'h00200, 8'h11, 0, 0, "R4 plain");
    wr(17'h05555, 8'hAA, 0, 1, "R4 cmd");
    wr(17'h00300, 8'h22, 0, 0, "R9 mismatch");
    wr(17'h02AAA, 8'h55, 0, 0, "R9 idle after mismatch");
  endtask

  task automatic t_relock_alias;
    wr(17'h05555, 8'hAA, 0, 1, "R5 b1");
    wr(17'h0AAAA, 8'h55, 0, 1, "R7 alias");
    wr(17'h05555, 8'hA0, 0, 1, "R5 b3");
    wr(17'h1FFFF, 8'h00, 1, 0, "R5 fourth");
    chk_prot(1'b1, "R5");
    wr(17'h15555, 8'hAA, 0, 0, "R7 main full");
  endtask

  task automatic t_restart;
    idle(1);
    wr(17'h05555, 8'hAA, 0, 1, "R9 b1");
    wr(17'h05555, 8'hAA, 0, 1, "R9 restart");
    wr(17'h02AAA, 8'h55, 0, 1, "R9 b2");
    wr(17'h05555, 8'hA0, 0, 1, "R9 b3");
    wr(17'h00400, 8'h44, 1, 0, "R9 fourth");
  endtask

  task automatic t_window;
    idle(1);
    wr(17'h05555, 8'hAA, 0, 1, "R8 b1");
    idle(W - 1);
    wr(17'h02AAA, 8'h55, 0, 1, "R8 gap at limit");
    idle(W);
    wr(17'h05555, 8'hA0, 0, 0, "R8 gap over");
    wr(17'h00500, 8'h55, 0, 0, "R8 no arm");
    // armed step also times out
    wr(17'h05555, 8'hAA, 0, 1, "R8 b1");
    wr(17'h02AAA, 8'h55, 0, 1, "R8 b2");
    wr(17'h05555, 8'hA0, 0, 1, "R8 b3");
    idle(W);
    wr(17'h05555, 8'hAA, 0, 1, "R8 arm expired");
    chk_prot(1'b1, "R8");
  endtask

  task automatic t_release;
    wr(17'h05555, 8'hAA, 0, 1, "R6 s1");
    wr(17'h02AAA, 8'h55, 0, 1, "R6 s2");
    wr(17'h05555, 8'h80, 0, 1, "R6 s3");
    wr(17'h05555, 8'hAA, 0, 1, "R6 s4");
    wr(17'h12AAA, 8'h55, 0, 1, "R6 s5");
    wr(17'h05555, 8'h20, 0, 1, "R6 s6");
    chk_prot(1'b0, "R6");
    wr(17'h00600, 8'h66, 1, 0, "R6 after");
  endtask

  initial begin
    t_reset();
    t_open_pass();
    t_lock();
    t_blocked();
    t_relock_alias();
    t_restart();
    t_window();
    t_release();
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule